// File: doc/BRIEF.md
# Self-Checking Tower-Field AES Substitution Byte

This block computes the forward AES substitution of one byte. The byte is inverted in GF(2^8) and then passed through the affine step. The inversion runs in a composite field: GF(2^8) over GF(2^4) over GF(2^2), with a normal basis at every level. A linear map converts the polynomial-basis input into that tower. On the way out, the inverse map and the affine transform are folded into a single constant matrix. There is one inverter and nothing is duplicated.

Faults are caught by computing each byte twice on the same logic. On a direct cycle (`recompute` low) the tower operand enters the inverter unchanged. On a recompute cycle (`recompute` high) the two 4-bit normal-basis halves are exchanged first. Swapping the halves of a normal-basis operand commutes with inversion. The recompute result therefore leaves through a second output matrix that undoes the swap, and on a fault-free circuit it must equal the direct result.

The block stores the direct result. On a recompute cycle that immediately follows a direct cycle, the recompute output is compared with the stored value. Any difference sets a registered error flag. The flag stays high until it is cleared. A persistent fault in the inverter sees different operand bits in the two passes, so it usually shows up as a mismatch.

Top module: `nb_sbox_checked`

## Requirements
- R1: With `recompute` low, `out_byte` equals the AES forward substitution of `in_byte` in the same cycle. The substitution is the GF(2^8) inverse under x^8+x^4+x^3+x+1, followed by s = M·c XOR 0x63. Row i of M has ones at bits i, i+4, i+5, i+6 and i+7 (mod 8).
- R2: An input of 0x00 gives 0x63, because zero maps to zero in the inversion.
- R3: With `recompute` high, `out_byte` equals the same substitution value for every input when the logic is fault-free.
- R4: A recompute cycle that directly follows a direct cycle compares its output with the direct output. A difference sets `err_flag`, which is visible after the clock edge that ends the recompute cycle. Equal outputs leave `err_flag` low.
- R5: `err_flag` is sticky. `clr_err` clears it at the next clock edge. If a mismatch is detected in the same cycle as `clr_err`, the flag is set.
- R6: A recompute cycle that follows another recompute cycle makes no comparison, whatever its output.
- R7: Reset is synchronous and active low. It leaves `err_flag` low.
- R8: A direct cycle never raises `err_flag`, even when the inverter is faulty.
- R9: Suppose the inverter's 8-bit tower-domain output is stuck at a value whose upper and lower nibbles differ. A direct/recompute pair then raises `err_flag`. If the stuck value has equal nibbles, the pair does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Byte to substitute |
| recompute | input | 1 | 0 = direct pass, 1 = pass with swapped normal-basis halves |
| clr_err | input | 1 | Synchronous clear of the error flag |
| out_byte | output | 8 | Substituted byte for the current pass |
| err_flag | output | 1 | Sticky mismatch indication |

## Verification
The bench sweeps all 256 bytes through both passes. A wrong basis matrix or a wrong swap in the output matrix would give either a wrong direct value or a recompute value that differs from the direct one, and the recompute mismatch would also raise a false alarm. Stuck values are forced onto the inverter output. A single-bit value or a burst value must be caught. A value with equal nibbles must not be caught, because the swap cannot expose it. A design that compared on every recompute cycle, let a clear override a fresh detection, or set the flag on direct cycles would fail the directed sequences for R6, R5 and R8.

// File: rtl/nb_sbox_pkg.sv
package nb_sbox_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    localparam logic [BYTE_W-1:0] AFF_CONST  = 8'h63;
    localparam logic [BYTE_W-1:0] FIELD_LOW  = 8'h1B;   // x^8 = x^4+x^3+x+1
    localparam logic [1:0]        GF4_NORM   = 2'b10;   // W^2 in [W^2,W]

    typedef logic [BYTE_W*BYTE_W-1:0] colset_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ref_byte;
        logic              armed;
        logic              err;
    } chk_state_t;

    // ---------------- polynomial-basis helpers (elaboration only) -----
    function automatic logic [7:0] pb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] pb_sq(input logic [7:0] a);
        return pb_mul(a, a);
    endfunction

    // first x (x > 1) with x^2 + x + k = 0
    function automatic logic [7:0] pb_root(input logic [7:0] k);
        logic [7:0] r;
        logic [7:0] cand;
        logic       hit;
        r   = '0;
        hit = 1'b0;
        for (int n = 2; n < 256; n++) begin
            cand = 8'(n);
            if (!hit && ((pb_sq(cand) ^ cand ^ k) == 8'h00)) begin
                r   = cand;
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    // ---------------- normal-basis tower arithmetic (synthesizable) ---
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        logic t;
        t = (a[1] ^ a[0]) & (b[1] ^ b[0]);
        return {(a[1] & b[1]) ^ t, (a[0] & b[0]) ^ t};
    endfunction

    // squaring and inversion in GF(4) normal basis are both a swap
    function automatic logic [1:0] gf4_swap(input logic [1:0] a);
        return {a[0], a[1]};
    endfunction

    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] t;
        t = gf4_mul(gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]), GF4_NORM);
        return {gf4_mul(a[3:2], b[3:2]) ^ t, gf4_mul(a[1:0], b[1:0]) ^ t};
    endfunction

    function automatic logic [3:0] gf16_inv(input logic [3:0] a);
        logic [1:0] e;
        logic [1:0] d;
        e = gf4_mul(a[3:2], a[1:0]) ^ gf4_mul(gf4_swap(a[3:2] ^ a[1:0]), GF4_NORM);
        d = gf4_swap(e);
        return {gf4_mul(d, a[1:0]), gf4_mul(d, a[3:2])};
    endfunction

    // smallest norm making y^2 + y + nu irreducible over GF(16)
    function automatic logic [3:0] pick_nu();
        logic [3:0] r;
        logic [3:0] v;
        logic [3:0] x;
        logic       ok;
        logic       hit;
        r   = 4'h1;
        hit = 1'b0;
        for (int n = 1; n < 16; n++) begin
            v  = 4'(n);
            ok = 1'b1;
            for (int m = 0; m < 16; m++) begin
                x = 4'(m);
                if ((gf16_mul(x, x) ^ x) == v) ok = 1'b0;
            end
            if (ok && !hit) begin
                r   = v;
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    localparam logic [3:0] GF16_NU = pick_nu();

    // ---------------- basis construction ------------------------------
    function automatic colset_t tower_cols();
        colset_t    cols;
        logic [7:0] w, w2, z, z4, y, y16, nu_p, fy, fz, fw;
        logic [2:0] ib;
        w    = pb_root(8'h01);
        w2   = pb_sq(w);
        z    = pb_root(w2);                       // norm W^2
        z4   = pb_sq(pb_sq(z));
        nu_p = (GF16_NU[3] ? pb_mul(z4, w2) : 8'h00) ^
               (GF16_NU[2] ? pb_mul(z4, w)  : 8'h00) ^
               (GF16_NU[1] ? pb_mul(z,  w2) : 8'h00) ^
               (GF16_NU[0] ? pb_mul(z,  w)  : 8'h00);
        y    = pb_root(nu_p);
        y16  = pb_sq(pb_sq(pb_sq(pb_sq(y))));
        cols = '0;
        for (int i = 0; i < 8; i++) begin
            ib = 3'(i);
            fy = ib[2] ? y16 : y;
            fz = ib[1] ? z4  : z;
            fw = ib[0] ? w2  : w;
            cols[i*8 +: 8] = pb_mul(fy, pb_mul(fz, fw));
        end
        return cols;
    endfunction

    function automatic logic [7:0] lin_apply(input colset_t cols, input logic [7:0] x);
        logic [7:0] acc;
        acc = '0;
        for (int j = 0; j < 8; j++)
            if (x[j]) acc = acc ^ cols[j*8 +: 8];
        return acc;
    endfunction

    function automatic colset_t poly_to_tower_cols();
        colset_t    t2p;
        colset_t    cols;
        logic [7:0] t;
        t2p  = tower_cols();
        cols = '0;
        for (int j = 0; j < 8; j++) begin
            for (int n = 0; n < 256; n++) begin
                t = 8'(n);
                if (lin_apply(t2p, t) == (8'h01 << j)) cols[j*8 +: 8] = t;
            end
        end
        return cols;
    endfunction

    function automatic logic [7:0] rot_down(input logic [7:0] x, input int k);
        return (x >> k) | (x << (8 - k));
    endfunction

    function automatic logic [7:0] affine_lin(input logic [7:0] x);
        return x ^ rot_down(x, 4) ^ rot_down(x, 5) ^ rot_down(x, 6) ^ rot_down(x, 7);
    endfunction

    function automatic colset_t direct_out_cols();
        colset_t t2p;
        colset_t cols;
        t2p = tower_cols();
        for (int i = 0; i < 8; i++)
            cols[i*8 +: 8] = affine_lin(t2p[i*8 +: 8]);
        return cols;
    endfunction

    // undoes the half swap: tower bit i reads the column of bit i^4
    function automatic colset_t swapped_out_cols();
        colset_t dir;
        colset_t cols;
        dir = direct_out_cols();
        for (int i = 0; i < 8; i++)
            cols[i*8 +: 8] = dir[(i ^ 4)*8 +: 8];
        return cols;
    endfunction

    localparam colset_t P2T_COLS  = poly_to_tower_cols();
    localparam colset_t DIR_COLS  = direct_out_cols();
    localparam colset_t SWAP_COLS = swapped_out_cols();

endpackage

// File: rtl/nb_linmap.sv
module nb_linmap #(
    parameter int               W      = 8,
    parameter logic [W*W-1:0]   COLS   = '0,
    parameter logic [W-1:0]     OFFSET = '0
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    for (genvar r = 0; r < W; r++) begin : g_row
        logic [W-1:0] row_mask;
        for (genvar c = 0; c < W; c++) begin : g_col
            assign row_mask[c] = COLS[c*W + r];
        end
        assign y_o[r] = (^(row_mask & x_i)) ^ OFFSET[r];
    end
endmodule

// File: rtl/nb_tower_inv.sv
module nb_tower_inv
    import nb_sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] c_o
);
    logic [NIB_W-1:0] hi, lo, sum, sum_sq, delta, delta_inv;

    always_comb begin
        hi        = a_i[BYTE_W-1:NIB_W];
        lo        = a_i[NIB_W-1:0];
        sum       = hi ^ lo;
        sum_sq    = gf16_mul(sum, sum);
        delta     = gf16_mul(hi, lo) ^ gf16_mul(sum_sq, GF16_NU);
        delta_inv = gf16_inv(delta);
        c_o       = {gf16_mul(delta_inv, lo), gf16_mul(delta_inv, hi)};
    end
endmodule

// File: rtl/nb_sbox_checked.sv
module nb_sbox_checked
    import nb_sbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              recompute,
    input  logic              clr_err,
    output logic [BYTE_W-1:0] out_byte,
    output logic              err_flag
);
    logic [BYTE_W-1:0] tw, inv_a, inv_c, dir_s, swp_s;
    logic              mismatch;
    chk_state_t        st_d, st_q;

    nb_linmap #(.W(BYTE_W), .COLS(P2T_COLS), .OFFSET(8'h00)) u_to_tower (
        .x_i (in_byte),
        .y_o (tw)
    );

    always_comb begin
        inv_a = recompute ? {tw[NIB_W-1:0], tw[BYTE_W-1:NIB_W]} : tw;
    end

    nb_tower_inv u_inv (
        .a_i (inv_a),
        .c_o (inv_c)
    );

    nb_linmap #(.W(BYTE_W), .COLS(DIR_COLS), .OFFSET(AFF_CONST)) u_out_dir (
        .x_i (inv_c),
        .y_o (dir_s)
    );

    nb_linmap #(.W(BYTE_W), .COLS(SWAP_COLS), .OFFSET(AFF_CONST)) u_out_swp (
        .x_i (inv_c),
        .y_o (swp_s)
    );

    always_comb begin
        out_byte = recompute ? swp_s : dir_s;
        mismatch = recompute && st_q.armed && (out_byte != st_q.ref_byte);
        st_d     = st_q;
        if (recompute) begin
            st_d.armed = 1'b0;
        end else begin
            st_d.armed    = 1'b1;
            st_d.ref_byte = out_byte;
        end
        if (clr_err)  st_d.err = 1'b0;
        if (mismatch) st_d.err = 1'b1;   // detection beats clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_flag = st_q.err;
endmodule

// File: rtl/nb_sbox_checked_chk.sv
module nb_sbox_checked_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] in_byte,
    input logic       recompute,
    input logic       clr_err,
    input logic [7:0] out_byte,
    input logic       err_flag
);
    logic       prev_dir_q;
    logic [7:0] prev_out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dir_q <= 1'b0;
            prev_out_q <= '0;
        end else begin
            prev_dir_q <= !recompute;
            prev_out_q <= out_byte;
        end
    end

    assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!recompute && in_byte == 8'h00) |-> (out_byte == 8'h63));

    assert_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && prev_dir_q && out_byte != prev_out_q) |=> err_flag);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !recompute) |=> !err_flag);

    assert_lone_recompute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && !prev_dir_q && !err_flag) |=> !err_flag);

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |=> !err_flag);

    assert_direct_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!recompute && !err_flag) |=> !err_flag);
endmodule

bind nb_sbox_checked nb_sbox_checked_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_byte   (in_byte),
    .recompute (recompute),
    .clr_err   (clr_err),
    .out_byte  (out_byte),
    .err_flag  (err_flag)
);

// File: tb/nb_sbox_checked_bench.sv
module nb_sbox_checked_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       recompute = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] out_byte;
    logic       err_flag;
    int         n_checks = 0;
    int         n_errs = 0;

    // known substitution pairs {input, output}
    localparam logic [15:0] KNOWN [8] = '{
        16'h0063, 16'h017C, 16'h0277, 16'h10CA,
        16'h53ED, 16'h80CD, 16'hC9DD, 16'hFF16
    };

    always #4 clk = ~clk;   // 8 ns period

    nb_sbox_checked u_nb_sbox_checked (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_byte   (in_byte),
        .recompute (recompute),
        .clr_err   (clr_err),
        .out_byte  (out_byte),
        .err_flag  (err_flag)
    );

    function automatic logic [7:0] xtime_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        while (bb != 8'h00) begin
            if (bb[0]) p = p ^ aa;
            aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1B : 8'h00);
            bb = bb >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] model_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] s;
        for (int b = 1; b < 256; b++)
            if (xtime_mul(x, 8'(b)) == 8'h01) inv = 8'(b);
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return s ^ 8'h63;
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // direct cycle then recompute cycle; returns at the negedge after the compare edge
    task automatic run_pair(input logic [7:0] x, input logic check_out, input logic clr_mid);
        @(negedge clk);
        in_byte = x; recompute = 1'b0; clr_err = 1'b0;
        #1;
        if (check_out) chk8("R1 direct value", out_byte, model_sbox(x));
        @(negedge clk);
        recompute = 1'b1; clr_err = clr_mid;
        #1;
        if (check_out) chk8("R3 recompute value", out_byte, model_sbox(x));
        @(negedge clk);
        recompute = 1'b0; clr_err = 1'b0;
        #1;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        recompute = 1'b0; clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] faults [5] = '{8'h01, 8'h80, 8'h0F, 8'h3C, 8'hA5};

        // R7: reset state
        repeat (3) @(negedge clk);
        #1;
        chk1("R7 flag after reset", err_flag, 1'b0);
        rst_n = 1'b1;

        // R1: known table
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_byte = KNOWN[k][15:8]; recompute = 1'b0;
            #1;
            chk8("R1 table entry", out_byte, KNOWN[k][7:0]);
        end

        // R1/R3/R4: every byte through both passes, no false alarm
        for (int x = 0; x < 256; x++) begin
            run_pair(8'(x), 1'b1, 1'b0);
            chk1("R4 no alarm on equal passes", err_flag, 1'b0);
        end

        // R2: zero input
        @(negedge clk);
        in_byte = 8'h00; recompute = 1'b0;
        #1;
        chk8("R2 zero maps to 63", out_byte, 8'h63);
        recompute = 1'b1;
        #1;
        chk8("R2 zero on recompute", out_byte, 8'h63);

        // R9/R4: stuck inverter outputs with unequal nibbles are caught
        for (int f = 0; f < 5; f++) begin
            clear_flag();
            chk1("R5 clear", err_flag, 1'b0);
            @(negedge clk);
            in_byte = 8'h35;
            force u_nb_sbox_checked.inv_c = faults[f];
            run_pair(8'h35, 1'b0, 1'b0);
            release u_nb_sbox_checked.inv_c;
            chk1("R9 stuck fault detected", err_flag, 1'b1);
        end

        // R5: flag holds through fault-free traffic
        run_pair(8'h12, 1'b0, 1'b0);
        run_pair(8'hE7, 1'b0, 1'b0);
        chk1("R5 flag sticky", err_flag, 1'b1);
        clear_flag();
        chk1("R5 clear after sticky", err_flag, 1'b0);

        // R9: equal-nibble stuck value escapes
        @(negedge clk);
        in_byte = 8'h35;
        force u_nb_sbox_checked.inv_c = 8'h77;
        run_pair(8'h35, 1'b0, 1'b0);
        release u_nb_sbox_checked.inv_c;
        chk1("R9 symmetric fault missed", err_flag, 1'b0);

        // R8: faulty direct cycles alone never raise the flag
        @(negedge clk);
        in_byte = 8'h35; recompute = 1'b0;
        force u_nb_sbox_checked.inv_c = 8'h01;
        repeat (4) @(negedge clk);
        release u_nb_sbox_checked.inv_c;
        #1;
        chk1("R8 direct cycles quiet", err_flag, 1'b0);

        // R6: second consecutive recompute is not compared
        @(negedge clk);
        in_byte = 8'h44; recompute = 1'b0;
        @(negedge clk);
        recompute = 1'b1;
        @(negedge clk);
        force u_nb_sbox_checked.inv_c = 8'h01;
        @(negedge clk);
        recompute = 1'b0;
        release u_nb_sbox_checked.inv_c;
        #1;
        chk1("R6 lone recompute ignored", err_flag, 1'b0);

        // R5: detection wins over a simultaneous clear
        @(negedge clk);
        in_byte = 8'h35;
        force u_nb_sbox_checked.inv_c = 8'h0F;
        run_pair(8'h35, 1'b0, 1'b1);
        release u_nb_sbox_checked.inv_c;
        chk1("R5 set beats clear", err_flag, 1'b1);

        // R7: reset in mid-run clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk1("R7 reset clears flag", err_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule